// File: doc/BRIEF.md
# Parallel RGB Data-Enable Recovery

This block sits behind a parallel video input that carries 24-bit pixels together with horizontal sync, vertical sync and a pixel clock, but no flag marking the visible area. It locks onto the incoming sync pulses and counts pixel clocks from each horizontal sync leading edge and lines from each vertical frame start. Using fixed porch and pulse widths, it places a window over the visible pixels and raises a data-enable flag there. A downstream link encoder uses that flag to choose between pixel symbols and control symbols; while the flag is low, only the two sync bits carry meaning.

The pixel word, both sync bits and the recovered enable leave through the same register stages, so all of them line up at the output. The block does not generate any timing of its own. It measures each line and each frame against the expected totals and keeps a sticky mismatch flag. The enable stays low, and the lock indicator stays low, until one complete frame has been observed after reset. All widths are parameters. The defaults describe a 1280x720, 60 Hz raster (74.25 MHz pixel clock): 1650 clocks per line and 750 lines per frame.

Top module: `vde_recover`

## Requirements
- R1: While `rst` is high, and on the clock edge that samples it, `de_out`, `locked`, `timing_err` and the pixel outputs go to 0, and each sync output goes to its inactive level (the inverse of its active-level parameter).
- R2: With `OUT_STAGES` = 1, the `red_out`, `green_out`, `blue_out`, `hsync_out` and `vsync_out` outputs equal the corresponding inputs sampled two clock edges earlier. The sync outputs keep the polarity they had at the input.
- R3: `de_out` is high exactly when two conditions hold for the pixel. First, its horizontal position lies in [H_SYNC+H_BACK, H_SYNC+H_BACK+H_ACTIVE), with position 0 being the pixel that carries the horizontal sync leading edge (default 260 to 1539). Second, its line number lies in [V_SYNC+V_BACK, V_SYNC+V_BACK+V_ACTIVE) (default 25 to 744). `de_out` has the same two-cycle latency as the pixel data.
- R4: A sync leading edge is a change from the inactive to the active level. The active level is high when `HS_ACT_HIGH` or `VS_ACT_HIGH` is 1, and low when it is 0.
- R5: The line containing a horizontal sync leading edge becomes line 0 when a vertical sync leading edge is seen on that same pixel, or on any pixel since the previous horizontal edge. A vertical edge in the middle of a line therefore starts the frame at the next line.
- R6: `de_out` and `locked` stay low until the second frame start after reset. `locked` goes high in the output cycle of the pixel that begins that frame and then stays high until reset.
- R7: `timing_err` goes high when a horizontal sync leading edge arrives after a line whose length differs from H_TOTAL. The first edge after reset is not checked. The flag then stays high until reset.
- R8: `timing_err` goes high when a frame starts after a frame whose line count differs from V_TOTAL. The first frame start after reset is not checked.
- R9: A reset applied while running clears `timing_err` and `locked`. Recovery then starts over, with a new full frame needed before lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| red_in | input | 8 | Red component of the incoming pixel |
| green_in | input | 8 | Green component of the incoming pixel |
| blue_in | input | 8 | Blue component of the incoming pixel |
| hsync_in | input | 1 | Incoming horizontal sync, polarity set by HS_ACT_HIGH |
| vsync_in | input | 1 | Incoming vertical sync, polarity set by VS_ACT_HIGH |
| red_out | output | 8 | Delayed red component |
| green_out | output | 8 | Delayed green component |
| blue_out | output | 8 | Delayed blue component |
| hsync_out | output | 1 | Delayed horizontal sync, input polarity |
| vsync_out | output | 1 | Delayed vertical sync, input polarity |
| de_out | output | 1 | Recovered visible-area enable, aligned with the pixel |
| locked | output | 1 | High once a full frame has been observed |
| timing_err | output | 1 | Sticky line or frame length mismatch |

## Verification
The bench builds the block with a reduced raster: 8 active pixels, porches of 2 and 3 clocks and a 2-clock pulse, giving 15 clocks per line. Vertically it uses 4 active lines, porches of 1 and 2 lines and a 1-line pulse, giving 8 lines per frame. At this size a whole frame is 120 clocks, so lock acquisition, frame starts after a mid-line vertical edge, and deliberately shortened lines and lengthened frames all fit in a few thousand cycles. Horizontal sync is set active-low and vertical sync active-high, so the inverted-polarity edge path and the non-inverted one are both exercised in the same run.

// File: rtl/vde_pkg.sv
package vde_pkg;

    // One pixel as carried through the block
    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // One output beat: pixel, raw sync bits and recovered enable
    typedef struct packed {
        rgb_t px;
        logic hs;
        logic vs;
        logic de;
    } vid_beat_t;

    // True when pos falls inside [lo, lo+len)
    function automatic logic in_span(input int unsigned pos,
                                     input int unsigned lo,
                                     input int unsigned len);
        return (pos >= lo) && (pos < lo + len);
    endfunction

endpackage

// File: rtl/vde_sync_edge.sv
module vde_sync_edge #(
    parameter bit ACT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic act,
    output logic lead
);

    logic act_d_q;

    // Normalise to active-high before looking for the edge
    generate
        if (ACT_HIGH) begin : g_pass
            assign act = raw;
        end else begin : g_inv
            assign act = ~raw;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d_q <= 1'b0;
        end else begin
            act_d_q <= act;
        end
    end

    assign lead = act & ~act_d_q;

endmodule

// File: rtl/vde_raster_track.sv
module vde_raster_track
    import vde_pkg::*;
#(
    parameter int H_ACTIVE = 1280,
    parameter int H_FRONT  = 110,
    parameter int H_SYNC   = 40,
    parameter int H_BACK   = 220,
    parameter int V_ACTIVE = 720,
    parameter int V_FRONT  = 5,
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic h_lead,
    input  logic v_lead,
    output logic de_win,
    output logic locked,
    output logic timing_err
);

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW      = $clog2(H_TOTAL + 1) + 1;
    localparam int VW      = $clog2(V_TOTAL + 1) + 1;
    localparam int H_OPEN  = H_SYNC + H_BACK;
    localparam int V_OPEN  = V_SYNC + V_BACK;
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_SAT  = '1;
    localparam logic [VW-1:0] V_SAT  = '1;

    logic [HW-1:0] hcnt_q, hpos;
    logic [VW-1:0] vline_q, vpos;
    logic          h_seen_q, v_seen_q, v_pend_q, lock_q, err_q;
    logic          v_trig, frame_start, h_bad, v_bad;

    // Position of the pixel currently in the capture stage
    always_comb begin
        v_trig      = v_lead | v_pend_q;
        frame_start = h_lead & v_trig;

        if (h_lead) begin
            hpos = '0;
        end else if (hcnt_q == H_SAT) begin
            hpos = H_SAT;
        end else begin
            hpos = hcnt_q + HW'(1);
        end

        if (frame_start) begin
            vpos = '0;
        end else if (h_lead && (vline_q != V_SAT)) begin
            vpos = vline_q + VW'(1);
        end else begin
            vpos = vline_q;
        end

        h_bad = h_lead & h_seen_q & (hcnt_q != H_LAST);
        v_bad = frame_start & v_seen_q & (vline_q != V_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q   <= '0;
            vline_q  <= '0;
            h_seen_q <= 1'b0;
            v_seen_q <= 1'b0;
            v_pend_q <= 1'b0;
            lock_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            hcnt_q  <= hpos;
            vline_q <= vpos;
            if (h_lead) begin
                h_seen_q <= 1'b1;
            end
            if (frame_start) begin
                v_seen_q <= 1'b1;
            end
            // A vertical edge waits for the next horizontal edge
            v_pend_q <= h_lead ? 1'b0 : (v_pend_q | v_lead);
            if (frame_start && v_seen_q) begin
                lock_q <= 1'b1;
            end
            if (h_bad || v_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign de_win = lock_q
                  & in_span(32'(hpos), H_OPEN, H_ACTIVE)
                  & in_span(32'(vpos), V_OPEN, V_ACTIVE);
    assign locked     = lock_q;
    assign timing_err = err_q;

endmodule

// File: rtl/vde_out_pipe.sv
module vde_out_pipe
    import vde_pkg::*;
#(
    parameter int        STAGES  = 1,
    parameter vid_beat_t RST_VAL = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  vid_beat_t d,
    output vid_beat_t q
);

    vid_beat_t stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            vid_beat_t nxt;
            if (i == 0) begin : g_head
                assign nxt = d;
            end else begin : g_tail
                assign nxt = stg_q[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q[i] <= RST_VAL;
                end else begin
                    stg_q[i] <= nxt;
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/vde_recover.sv
module vde_recover
    import vde_pkg::*;
#(
    parameter int H_ACTIVE    = 1280,
    parameter int H_FRONT     = 110,
    parameter int H_SYNC      = 40,
    parameter int H_BACK      = 220,
    parameter int V_ACTIVE    = 720,
    parameter int V_FRONT     = 5,
    parameter int V_SYNC      = 5,
    parameter int V_BACK      = 20,
    parameter bit HS_ACT_HIGH = 1'b1,
    parameter bit VS_ACT_HIGH = 1'b1,
    parameter int OUT_STAGES  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] red_in,
    input  logic [7:0] green_in,
    input  logic [7:0] blue_in,
    input  logic       hsync_in,
    input  logic       vsync_in,
    output logic [7:0] red_out,
    output logic [7:0] green_out,
    output logic [7:0] blue_out,
    output logic       hsync_out,
    output logic       vsync_out,
    output logic       de_out,
    output logic       locked,
    output logic       timing_err
);

    localparam vid_beat_t IDLE_BEAT = '{px: '0, hs: !HS_ACT_HIGH,
                                        vs: !VS_ACT_HIGH, de: 1'b0};

    vid_beat_t cap_q, pipe_in, pipe_out;
    logic      hs_act, vs_act, h_lead, v_lead, de_win;

    // Capture stage: every input goes through exactly one register here
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= IDLE_BEAT;
        end else begin
            cap_q <= '{px: '{r: red_in, g: green_in, b: blue_in},
                       hs: hsync_in, vs: vsync_in, de: 1'b0};
        end
    end

    vde_sync_edge #(.ACT_HIGH(HS_ACT_HIGH)) u_hedge (
        .clk  (clk),
        .rst  (rst),
        .raw  (cap_q.hs),
        .act  (hs_act),
        .lead (h_lead)
    );

    vde_sync_edge #(.ACT_HIGH(VS_ACT_HIGH)) u_vedge (
        .clk  (clk),
        .rst  (rst),
        .raw  (cap_q.vs),
        .act  (vs_act),
        .lead (v_lead)
    );

    vde_raster_track #(
        .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK),
        .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC), .V_BACK (V_BACK)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .h_lead     (h_lead),
        .v_lead     (v_lead),
        .de_win     (de_win),
        .locked     (locked),
        .timing_err (timing_err)
    );

    always_comb begin
        pipe_in    = cap_q;
        pipe_in.de = de_win;
    end

    vde_out_pipe #(.STAGES(OUT_STAGES), .RST_VAL(IDLE_BEAT)) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (pipe_in),
        .q   (pipe_out)
    );

    assign red_out   = pipe_out.px.r;
    assign green_out = pipe_out.px.g;
    assign blue_out  = pipe_out.px.b;
    assign hsync_out = pipe_out.hs;
    assign vsync_out = pipe_out.vs;
    assign de_out    = pipe_out.de;

    // Normalised syncs are only needed by the edge finders
    logic unused_act;
    assign unused_act = hs_act ^ vs_act;

endmodule

// File: rtl/vde_recover_chk.sv
module vde_recover_chk #(
    parameter bit HS_ACT_HIGH = 1'b1,
    parameter bit VS_ACT_HIGH = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic de_out,
    input logic hsync_out,
    input logic vsync_out,
    input logic locked,
    input logic timing_err
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!de_out && !locked && !timing_err));

    // R6
    no_de_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !locked |-> !de_out);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> timing_err);

    // R3
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
        de_out |-> ((hsync_out != HS_ACT_HIGH) && (vsync_out != VS_ACT_HIGH)));

endmodule

bind vde_recover vde_recover_chk #(
    .HS_ACT_HIGH (HS_ACT_HIGH),
    .VS_ACT_HIGH (VS_ACT_HIGH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .de_out     (de_out),
    .hsync_out  (hsync_out),
    .vsync_out  (vsync_out),
    .locked     (locked),
    .timing_err (timing_err)
);

// File: tb/vde_recover_test.sv
`timescale 1ns/1ps
module vde_recover_test;

    localparam int HA = 8, HF = 2, HS = 2, HB = 3;
    localparam int VA = 4, VF = 1, VS = 1, VB = 2;
    localparam int H_TOTAL = HA + HF + HS + HB;
    localparam int V_TOTAL = VA + VF + VS + VB;
    localparam int H_OPEN = HS + HB;
    localparam int V_OPEN = VS + VB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] red_in = '0, green_in = '0, blue_in = '0;
    logic       hsync_in = 1'b1;   // active-low, idle high
    logic       vsync_in = 1'b0;   // active-high, idle low
    logic [7:0] red_out, green_out, blue_out;
    logic       hsync_out, vsync_out, de_out, locked, timing_err;

    vde_recover #(
        .H_ACTIVE (HA), .H_FRONT (HF), .H_SYNC (HS), .H_BACK (HB),
        .V_ACTIVE (VA), .V_FRONT (VF), .V_SYNC (VS), .V_BACK (VB),
        .HS_ACT_HIGH (1'b0), .VS_ACT_HIGH (1'b1), .OUT_STAGES (1)
    ) uut (
        .clk (clk), .rst (rst),
        .red_in (red_in), .green_in (green_in), .blue_in (blue_in),
        .hsync_in (hsync_in), .vsync_in (vsync_in),
        .red_out (red_out), .green_out (green_out), .blue_out (blue_out),
        .hsync_out (hsync_out), .vsync_out (vsync_out),
        .de_out (de_out), .locked (locked), .timing_err (timing_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Two-deep queue of expected outputs
    bit          pv  [2];
    logic [23:0] ppx [2];
    bit          phs [2], pvs [2], pde [2], plk [2], per [2];
    string       ptag[2];

    // Reference state derived from the requirements
    bit lock_exp, err_exp, prev_short;
    int frames_started, prev_lines;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_model();
        lock_exp = 1'b0; err_exp = 1'b0; prev_short = 1'b0;
        frames_started = 0; prev_lines = V_TOTAL;
        pv[0] = 1'b0; pv[1] = 1'b0;
    endtask

    task automatic step(input logic [23:0] px, input bit hs_a, input bit vs_a,
                        input bit de_e, input string tag);
        @(negedge clk);
        if (pv[1]) begin
            chk("R2", "rgb", 32'({red_out, green_out, blue_out}), 32'(ppx[1]));
            chk("R4", "hsync", 32'(hsync_out), 32'(!phs[1]));
            chk("R2", "vsync", 32'(vsync_out), 32'(pvs[1]));
            chk(ptag[1], "de", 32'(de_out), 32'(pde[1]));
            chk("R6", "locked", 32'(locked), 32'(plk[1]));
            chk("R7", "timing_err", 32'(timing_err), 32'(per[1]));
        end
        pv[1] = pv[0]; ppx[1] = ppx[0]; phs[1] = phs[0]; pvs[1] = pvs[0];
        pde[1] = pde[0]; plk[1] = plk[0]; per[1] = per[0]; ptag[1] = ptag[0];
        pv[0] = 1'b1; ppx[0] = px; phs[0] = hs_a; pvs[0] = vs_a;
        pde[0] = de_e; plk[0] = lock_exp; per[0] = err_exp; ptag[0] = tag;
        rst = 1'b0;
        {red_in, green_in, blue_in} = px;
        hsync_in = !hs_a;
        vsync_in = vs_a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(24'($urandom), 1'b0, 1'b0, 1'b0, "R3");
        end
    endtask

    // nlines lines; short_line is one clock shorter; early raises vsync mid last line
    task automatic send_frame(input int nlines, input int short_line,
                              input bit early, input string tag);
        for (int l = 0; l < nlines; l++) begin
            int len;
            len = (l == short_line) ? H_TOTAL - 1 : H_TOTAL;
            for (int h = 0; h < len; h++) begin
                bit win, vs_a;
                if (h == 0) begin
                    if (prev_short) err_exp = 1'b1;       // R7
                    prev_short = 1'b0;
                    if (l == 0) begin
                        if (frames_started > 0 && prev_lines != V_TOTAL)
                            err_exp = 1'b1;               // R8
                        frames_started++;
                        if (frames_started >= 2) lock_exp = 1'b1;
                    end
                end
                win  = (h >= H_OPEN) && (h < H_OPEN + HA) &&
                       (l >= V_OPEN) && (l < V_OPEN + VA);
                vs_a = (l < VS) || (early && (l == nlines - 1) && (h >= 7));
                step(24'($urandom), h < HS, vs_a, lock_exp && win, tag);
            end
            prev_short = (len != H_TOTAL);
        end
        prev_lines = nlines;
    endtask

    task automatic apply_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        hsync_in = 1'b1; vsync_in = 1'b0;
        clear_model();
        repeat (2) @(negedge clk);
        chk(tag, "de reset", 32'(de_out), 32'(0));
        chk(tag, "locked reset", 32'(locked), 32'(0));
        chk(tag, "err reset", 32'(timing_err), 32'(0));
        chk(tag, "hsync idle", 32'(hsync_out), 32'(1));
        chk(tag, "vsync idle", 32'(vsync_out), 32'(0));
        chk(tag, "rgb reset", 32'({red_out, green_out, blue_out}), 32'(0));
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        clear_model();
        repeat (3) @(negedge clk);
        chk("R1", "de reset", 32'(de_out), 32'(0));
        chk("R1", "locked reset", 32'(locked), 32'(0));
        chk("R1", "err reset", 32'(timing_err), 32'(0));
        chk("R1", "hsync idle", 32'(hsync_out), 32'(1));
        chk("R1", "vsync idle", 32'(vsync_out), 32'(0));

        // Random idle lead-in, then clean frames: first one is not enabled (R6)
        idle(1 + int'($urandom_range(20)));
        send_frame(V_TOTAL, -1, 1'b0, "R6");
        send_frame(V_TOTAL, -1, 1'b0, "R3");
        send_frame(V_TOTAL, -1, 1'b0, "R3");

        // Vertical edge in the middle of the last line (R5)
        send_frame(V_TOTAL, -1, 1'b1, "R5");
        send_frame(V_TOTAL, -1, 1'b0, "R5");
        chk("R5", "no error after mid-line vsync", 32'(timing_err), 32'(0));

        // Short line raises the sticky flag (R7)
        send_frame(V_TOTAL, 5, 1'b0, "R7");
        send_frame(V_TOTAL, -1, 1'b0, "R7");
        send_frame(V_TOTAL, -1, 1'b0, "R7");

        // Reset while running (R9), relock, then an over-long frame (R8)
        apply_reset("R9");
        idle(1 + int'($urandom_range(10)));
        send_frame(V_TOTAL, -1, 1'b0, "R9");
        send_frame(V_TOTAL, -1, 1'b0, "R3");
        send_frame(V_TOTAL + 1, -1, 1'b0, "R8");
        send_frame(V_TOTAL, -1, 1'b0, "R8");
        idle(2);
        chk("R8", "err after long frame", 32'(timing_err), 32'(1));
        chk("R6", "lock kept", 32'(locked), 32'(1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule